// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small word-addressed store in which each 64-bit word carries a presence flag (full or empty) and two trap flags. Requesters send one operation per handshake: a plain read, a plain write, a consuming read that waits for a full word, a producing write that waits for an empty word, an atomic fetch-and-add, or a tag write that sets the trap flags. Plain and atomic operations complete one cycle after acceptance.

A waiting operation whose presence condition is not met is not bounced back to the requester. It is parked inside the block. Every operation that flips a presence flag wakes all parked entries. The woken entries are retried one per cycle in round-robin slot order and use the same single memory port as new requests. Each failed retry advances a per-entry counter. When the counter reaches the programmable `retry_limit`, the request ends with a timeout status. Responses carry the requester's tag, so parked requests may complete out of order.

Top module: `fe_tagged_mem`

## Requirements
- R1: After reset every word reads as zero and empty with clear trap flags, `rsp_valid` is low, nothing is parked, and `req_ready` is high.
- R2: A plain read (op 0) returns the word with status OK (0) in the cycle after acceptance and leaves the presence flag unchanged.
- R3: A plain write (op 1) stores the data and marks the word full, and it answers OK with zero data.
- R4: A consuming read (op 2) to a full word returns the data and marks the word empty in one step. On an empty word it is parked and gives no response until it completes.
- R5: A producing write (op 3) to an empty word stores the data and marks it full, answering OK with zero data. On a full word it is parked.
- R6: Fetch-and-add (op 4) returns the old word and stores the old word plus the request data, modulo 2^64. It neither checks nor changes the presence flag.
- R7: A parked request takes the lowest free slot of a 4-slot queue. A request that flips any presence flag marks every occupied slot for retry. While any slot is marked, one marked slot per cycle is retried, searching upward (with wrap) from the slot after the last one served. A retry that succeeds responds OK with the original tag.
- R8: A failed retry increments that slot's counter. Once the count reaches `retry_limit`, the slot is freed and answers with status TIMEOUT (2) and zero data, and the word is left unchanged.
- R9: A tag write (op 5) sets the word's trap flags from `req_tag` and answers OK. Any other operation, including a retry, to a word with a nonzero trap field answers TRAP (1) with zero data and changes nothing.
- R10: `req_ready` is low while any slot is marked for retry. It is also low when all four slots are occupied and the offered request would have to park. Other requests are still accepted when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retry_limit | input | 8 | Failed retries before timeout |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_op | input | 3 | Operation code (0..5) |
| req_addr | input | 4 | Word address |
| req_data | input | 64 | Write data or addend |
| req_tag | input | 2 | Trap flags for a tag write |
| req_id | input | 4 | Requester tag echoed in the response |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | 4 | Tag of the answered request |
| rsp_data | output | 64 | Read or old value |
| rsp_status | output | 2 | 0 OK, 1 TRAP, 2 TIMEOUT |

## Verification
The first patterns are plain reads and writes and fetch-and-add with carry-out. They show whether data and presence are handled apart from any waiting. Consuming and producing pairs on one word show whether a parked entry is woken by the presence flip of its partner. A full four-slot queue with one satisfied entry among unsatisfied ones shows that round-robin order, hold-off and counter-driven timeouts interact correctly. Trap flags set under a parked entry show that the trap check also applies on retries.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int DATA_W = 64;
  localparam int TRAP_W = 2;

  typedef enum logic [2:0] {
    OP_LD   = 3'd0,
    OP_ST   = 3'd1,
    OP_SLD  = 3'd2,
    OP_SST  = 3'd3,
    OP_FAA  = 3'd4,
    OP_TAGW = 3'd5
  } fe_op_e;

  typedef enum logic [1:0] {
    RS_OK      = 2'd0,
    RS_TRAP    = 2'd1,
    RS_TIMEOUT = 2'd2
  } fe_status_e;
endpackage

// File: rtl/fe_store.sv
module fe_store
  import fe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fe,
  output logic [TRAP_W-1:0] rd_trap,
  input  logic              we_data,
  input  logic              we_fe,
  input  logic              we_trap,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_fe,
  input  logic [TRAP_W-1:0] wr_trap
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  fe_q;
  logic [TRAP_W-1:0] trap_q [DEPTH];

  assign rd_data = data_q[addr];
  assign rd_fe   = fe_q[addr];
  assign rd_trap = trap_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= '0;
        trap_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (addr == AW'(i)) begin
          if (we_data) data_q[i] <= wr_data;
          if (we_fe)   fe_q[i]   <= wr_fe;
          if (we_trap) trap_q[i] <= wr_trap;
        end
      end
    end
  end
endmodule

// File: rtl/fe_exec.sv
module fe_exec
  import fe_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] cur_data,
  input  logic              cur_fe,
  input  logic [TRAP_W-1:0] cur_trap,
  input  logic [DATA_W-1:0] arg_data,
  input  logic [TRAP_W-1:0] arg_tag,
  output logic              trap_hit,
  output logic              blocked,
  output logic              we_data,
  output logic              we_fe,
  output logic              we_trap,
  output logic [DATA_W-1:0] new_data,
  output logic              new_fe,
  output logic [TRAP_W-1:0] new_trap,
  output logic [DATA_W-1:0] out_data,
  output logic              fe_flip
);
  fe_op_e opc;
  assign opc = fe_op_e'(op);

  always_comb begin
    trap_hit = (opc != OP_TAGW) && (cur_trap != '0);
    blocked  = 1'b0;
    we_data  = 1'b0;
    we_fe    = 1'b0;
    we_trap  = 1'b0;
    new_data = arg_data;
    new_fe   = cur_fe;
    new_trap = arg_tag;
    out_data = '0;
    if (!trap_hit) begin
      unique case (opc)
        OP_LD:  out_data = cur_data;
        OP_ST: begin
          we_data = 1'b1;
          we_fe   = 1'b1;
          new_fe  = 1'b1;
        end
        OP_SLD: begin
          if (cur_fe) begin
            out_data = cur_data;
            we_fe    = 1'b1;
            new_fe   = 1'b0;
          end else begin
            blocked = 1'b1;
          end
        end
        OP_SST: begin
          if (!cur_fe) begin
            we_data = 1'b1;
            we_fe   = 1'b1;
            new_fe  = 1'b1;
          end else begin
            blocked = 1'b1;
          end
        end
        OP_FAA: begin
          out_data = cur_data;
          we_data  = 1'b1;
          new_data = cur_data + arg_data;
        end
        OP_TAGW: we_trap = 1'b1;
        default: out_data = '0;
      endcase
    end
    fe_flip = we_fe && (new_fe != cur_fe);
  end
endmodule

// File: rtl/fe_park_queue.sv
module fe_park_queue
  import fe_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int AW     = 4,
  parameter int IDW    = 4,
  parameter int CNTW   = 8,
  localparam int QIW   = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq,
  input  logic              enq_sst,
  input  logic [AW-1:0]     enq_addr,
  input  logic [DATA_W-1:0] enq_data,
  input  logic [IDW-1:0]    enq_id,
  input  logic              serve_free,
  input  logic [CNTW-1:0]   serve_cnt,
  input  logic              wake,
  output logic              pick_valid,
  output logic              pick_sst,
  output logic [AW-1:0]     pick_addr,
  output logic [DATA_W-1:0] pick_data,
  output logic [IDW-1:0]    pick_id,
  output logic [CNTW-1:0]   pick_cnt,
  output logic              full
);
  logic [QDEPTH-1:0] vld_q, vld_n, pend_q, pend_n, sst_q, sst_n;
  logic [AW-1:0]     addr_q [QDEPTH];
  logic [AW-1:0]     addr_n [QDEPTH];
  logic [DATA_W-1:0] data_q [QDEPTH];
  logic [DATA_W-1:0] data_n [QDEPTH];
  logic [IDW-1:0]    id_q   [QDEPTH];
  logic [IDW-1:0]    id_n   [QDEPTH];
  logic [CNTW-1:0]   cnt_q  [QDEPTH];
  logic [CNTW-1:0]   cnt_n  [QDEPTH];
  logic [QIW-1:0]    rr_q, rr_n, pick_idx, free_idx;

  assign full = &vld_q;

  always_comb begin
    logic [QIW-1:0] idx;
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int k = 0; k < QDEPTH; k++) begin
      idx = rr_q + QIW'(k);
      if (!pick_valid && vld_q[idx] && pend_q[idx]) begin
        pick_valid = 1'b1;
        pick_idx   = idx;
      end
    end
    free_idx = '0;
    for (int k = QDEPTH - 1; k >= 0; k--) begin
      if (!vld_q[k]) free_idx = QIW'(k);
    end
  end

  assign pick_sst  = sst_q[pick_idx];
  assign pick_addr = addr_q[pick_idx];
  assign pick_data = data_q[pick_idx];
  assign pick_id   = id_q[pick_idx];
  assign pick_cnt  = cnt_q[pick_idx];

  always_comb begin
    vld_n  = vld_q;
    pend_n = pend_q;
    sst_n  = sst_q;
    addr_n = addr_q;
    data_n = data_q;
    id_n   = id_q;
    cnt_n  = cnt_q;
    rr_n   = rr_q;
    if (pick_valid) begin
      pend_n[pick_idx] = 1'b0;
      cnt_n[pick_idx]  = serve_cnt;
      if (serve_free) vld_n[pick_idx] = 1'b0;
      rr_n = pick_idx + 1'b1;
    end
    if (enq) begin
      vld_n[free_idx]  = 1'b1;
      pend_n[free_idx] = 1'b0;
      sst_n[free_idx]  = enq_sst;
      addr_n[free_idx] = enq_addr;
      data_n[free_idx] = enq_data;
      id_n[free_idx]   = enq_id;
      cnt_n[free_idx]  = '0;
    end
    if (wake) pend_n = pend_n | vld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      pend_q <= '0;
      sst_q  <= '0;
      rr_q   <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
        id_q[i]   <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      vld_q  <= vld_n;
      pend_q <= pend_n;
      sst_q  <= sst_n;
      rr_q   <= rr_n;
      addr_q <= addr_n;
      data_q <= data_n;
      id_q   <= id_n;
      cnt_q  <= cnt_n;
    end
  end

  assert_no_enq_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enq |-> !full);
  assert_pick_only_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (vld_q[pick_idx] && pend_q[pick_idx]));
endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem
  import fe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int QDEPTH = 4,
  parameter int IDW    = 4,
  parameter int CNTW   = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNTW-1:0]   retry_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TRAP_W-1:0] req_tag,
  input  logic [IDW-1:0]    req_id,
  output logic              rsp_valid,
  output logic [IDW-1:0]    rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_status
);
  logic              pick_valid, pick_sst, q_full;
  logic [AW-1:0]     pick_addr, x_addr;
  logic [DATA_W-1:0] pick_data, x_data, cur_data, new_data, out_data;
  logic [IDW-1:0]    pick_id, x_id;
  logic [CNTW-1:0]   pick_cnt, cnt_inc;
  logic [2:0]        x_op;
  logic [TRAP_W-1:0] x_tag, cur_trap, new_trap;
  logic              cur_fe, new_fe, trap_hit, blocked, fe_flip;
  logic              ex_we_data, ex_we_fe, ex_we_trap;
  logic              fire_new, active, commit, timeout, serve_free, enq, wake;
  logic              rsp_valid_n;
  logic [IDW-1:0]    rsp_id_n;
  logic [DATA_W-1:0] rsp_data_n;
  logic [1:0]        rsp_status_n;

  // Retries own the port whenever one is pending.
  always_comb begin
    if (pick_valid) begin
      x_op   = pick_sst ? OP_SST : OP_SLD;
      x_addr = pick_addr;
      x_data = pick_data;
      x_tag  = '0;
      x_id   = pick_id;
    end else begin
      x_op   = req_op;
      x_addr = req_addr;
      x_data = req_data;
      x_tag  = req_tag;
      x_id   = req_id;
    end
  end

  fe_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(x_addr),
    .rd_data(cur_data), .rd_fe(cur_fe), .rd_trap(cur_trap),
    .we_data(ex_we_data && commit), .we_fe(ex_we_fe && commit),
    .we_trap(ex_we_trap && commit),
    .wr_data(new_data), .wr_fe(new_fe), .wr_trap(new_trap)
  );

  fe_exec u_exec (
    .op(x_op), .cur_data(cur_data), .cur_fe(cur_fe), .cur_trap(cur_trap),
    .arg_data(x_data), .arg_tag(x_tag), .trap_hit(trap_hit), .blocked(blocked),
    .we_data(ex_we_data), .we_fe(ex_we_fe), .we_trap(ex_we_trap),
    .new_data(new_data), .new_fe(new_fe), .new_trap(new_trap),
    .out_data(out_data), .fe_flip(fe_flip)
  );

  assign req_ready  = !pick_valid && !(q_full && blocked);
  assign fire_new   = req_valid && req_ready;
  assign active     = pick_valid || fire_new;
  assign commit     = active && !trap_hit && !blocked;
  assign cnt_inc    = pick_cnt + 1'b1;
  assign timeout    = pick_valid && blocked && (cnt_inc >= retry_limit);
  assign serve_free = trap_hit || !blocked || timeout;
  assign enq        = fire_new && blocked;
  assign wake       = commit && fe_flip;

  fe_park_queue #(.QDEPTH(QDEPTH), .AW(AW), .IDW(IDW), .CNTW(CNTW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .enq(enq), .enq_sst(x_op == OP_SST), .enq_addr(x_addr),
    .enq_data(x_data), .enq_id(x_id),
    .serve_free(serve_free), .serve_cnt(cnt_inc), .wake(wake),
    .pick_valid(pick_valid), .pick_sst(pick_sst), .pick_addr(pick_addr),
    .pick_data(pick_data), .pick_id(pick_id), .pick_cnt(pick_cnt), .full(q_full)
  );

  always_comb begin
    rsp_valid_n  = pick_valid ? serve_free : (fire_new && !blocked);
    rsp_id_n     = x_id;
    rsp_status_n = trap_hit ? RS_TRAP : (blocked ? RS_TIMEOUT : RS_OK);
    rsp_data_n   = (trap_hit || blocked) ? '0 : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_id     <= '0;
      rsp_data   <= '0;
      rsp_status <= '0;
    end else begin
      rsp_valid <= rsp_valid_n;
      if (rsp_valid_n) begin
        rsp_id     <= rsp_id_n;
        rsp_data   <= rsp_data_n;
        rsp_status <= rsp_status_n;
      end
    end
  end

  assert_hold_off_on_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> !req_ready);
  assert_plain_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_LD) |=> rsp_valid);
  assert_timeout_from_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == RS_TIMEOUT) |-> $past(pick_valid));
  assert_faa_keeps_presence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_new && req_op == OP_FAA) |-> !ex_we_fe);
  assert_trap_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && trap_hit) |-> !(ex_we_data || ex_we_fe || ex_we_trap));
endmodule

// File: tb/sim_fe_tagged_mem.sv
module sim_fe_tagged_mem;
  localparam int DEPTH = 16;
  localparam int QD    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  lim;
  logic        req_valid, req_ready;
  logic [2:0]  req_op;
  logic [3:0]  req_addr, req_id;
  logic [63:0] req_data;
  logic [1:0]  req_tag;
  logic        rsp_valid;
  logic [3:0]  rsp_id;
  logic [63:0] rsp_data;
  logic [1:0]  rsp_status;

  always #2 clk = ~clk;

  fe_tagged_mem u0 (
    .clk(clk), .rst_n(rst_n), .retry_limit(lim), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_tag(req_tag), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .rsp_status(rsp_status)
  );

  int checks = 0, fails = 0, cycles = 0, timeouts_seen = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [63:0] m_data [DEPTH];
  bit          m_fe   [DEPTH];
  logic [1:0]  m_trap [DEPTH];
  bit          p_v [QD], p_pend [QD];
  int          p_op [QD], p_addr [QD], p_id [QD], p_cnt [QD];
  logic [63:0] p_data [QD];
  int          rr = 0;
  bit          e_v = 0;
  int          e_id, e_st;
  logic [63:0] e_data;

  task automatic check(input string req, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit blk(input int op, input int a);
    return m_trap[a] == 0 && ((op == 2 && !m_fe[a]) || (op == 3 && m_fe[a]));
  endfunction

  // returns 0 done, 1 trap, 2 blocked; applies effects when done
  task automatic run_op(input int op, input int a, input logic [63:0] d,
                        input logic [1:0] tg, output int res,
                        output logic [63:0] rd, output bit flip);
    rd = 0; flip = 0;
    if (op != 5 && m_trap[a] != 0) begin res = 1; return; end
    if (blk(op, a)) begin res = 2; return; end
    res = 0;
    case (op)
      0: rd = m_data[a];
      1: begin flip = !m_fe[a]; m_data[a] = d; m_fe[a] = 1; end
      2: begin rd = m_data[a]; m_fe[a] = 0; flip = 1; end
      3: begin m_data[a] = d; m_fe[a] = 1; flip = 1; end
      4: begin rd = m_data[a]; m_data[a] = m_data[a] + d; end
      default: m_trap[a] = tg;
    endcase
  endtask

  task automatic wake_all();
    for (int j = 0; j < QD; j++) if (p_v[j]) p_pend[j] = 1;
  endtask

  task automatic step(input bit v, input int op, input int a, input logic [63:0] d,
                      input logic [1:0] tg, input int id, output bit acc);
    int res, idx; logic [63:0] rd; bit flip, any, full, mready;
    @(negedge clk);
    // compare registered response against last prediction
    check(cur_req, rsp_valid == e_v, "rsp_valid", 64'(rsp_valid), 64'(e_v));
    if (e_v && rsp_valid) begin
      check(cur_req, rsp_id == 4'(e_id), "rsp_id", 64'(rsp_id), 64'(e_id));
      check(cur_req, rsp_data == e_data, "rsp_data", rsp_data, e_data);
      check(cur_req, rsp_status == 2'(e_st), "rsp_status", 64'(rsp_status), 64'(e_st));
      if (rsp_status == 2) timeouts_seen++;
    end
    req_valid = v; req_op = 3'(op); req_addr = 4'(a);
    req_data = d; req_tag = tg; req_id = 4'(id);
    #1;
    e_v = 0; any = 0; idx = 0;
    for (int k = 0; k < QD; k++) begin
      int j = (rr + k) % QD;
      if (!any && p_v[j] && p_pend[j]) begin any = 1; idx = j; end
    end
    full = 1;
    for (int j = 0; j < QD; j++) if (!p_v[j]) full = 0;
    if (any) begin
      mready = 0;
      run_op(p_op[idx], p_addr[idx], p_data[idx], 2'b00, res, rd, flip);
      p_pend[idx] = 0;
      e_id = p_id[idx];
      if (res == 1) begin e_v = 1; e_st = 1; e_data = 0; p_v[idx] = 0; end
      else if (res == 2) begin
        p_cnt[idx]++;
        if (p_cnt[idx] >= int'(lim)) begin e_v = 1; e_st = 2; e_data = 0; p_v[idx] = 0; end
      end else begin
        e_v = 1; e_st = 0; e_data = rd; p_v[idx] = 0;
        if (flip) wake_all();
      end
      rr = (idx + 1) % QD;
    end else begin
      mready = !(full && blk(op, a));
      if (v && mready) begin
        run_op(op, a, d, tg, res, rd, flip);
        e_id = id;
        if (res == 1) begin e_v = 1; e_st = 1; e_data = 0; end
        else if (res == 2) begin
          int f = -1;
          for (int j = QD - 1; j >= 0; j--) if (!p_v[j]) f = j;
          p_v[f] = 1; p_pend[f] = 0; p_op[f] = op; p_addr[f] = a;
          p_data[f] = d; p_id[f] = id; p_cnt[f] = 0;
        end else begin
          e_v = 1; e_st = 0; e_data = rd;
          if (flip) wake_all();
        end
      end
    end
    check(any ? "R10" : cur_req, req_ready == mready, "req_ready",
          64'(req_ready), 64'(mready));
    acc = v && mready;
  endtask

  task automatic issue(input int op, input int a, input logic [63:0] d,
                       input logic [1:0] tg, input int id);
    bit acc = 0;
    for (int n = 0; n < 60 && !acc; n++) step(1, op, a, d, tg, id, acc);
    check(cur_req, acc, "accepted", 64'(acc), 64'd1);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, acc);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = 0; m_fe[i] = 0; m_trap[i] = 0; end
    for (int j = 0; j < QD; j++) begin p_v[j] = 0; p_pend[j] = 0; end
    rst_n = 0; lim = 8'd3; req_valid = 0; req_op = 0; req_addr = 0;
    req_data = 0; req_tag = 0; req_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, zero empty words
    cur_req = "R1"; idle(2);
    check("R1", req_ready == 1'b1, "ready after reset", 64'(req_ready), 64'd1);
    issue(0, 3, 0, 0, 1); idle(1);
    // R2, R3: plain write then read
    cur_req = "R3"; issue(1, 1, 64'hA5A5_0000_1234_5678, 0, 2);
    cur_req = "R2"; issue(0, 1, 0, 0, 3); issue(0, 1, 0, 0, 4); idle(1);
    // R4: consume full word, then park on empty, woken by plain write
    cur_req = "R4"; issue(2, 1, 0, 0, 5); issue(2, 1, 0, 0, 6); idle(2);
    issue(1, 1, 64'hBEEF, 0, 7); idle(3);
    // R5: produce on empty, park on full, consumer releases it
    cur_req = "R5"; issue(3, 2, 64'h22, 0, 8); issue(3, 2, 64'h33, 0, 9); idle(1);
    issue(2, 2, 0, 0, 10); idle(3); issue(0, 2, 0, 0, 11); idle(1);
    // R6: fetch-and-add with wrap, presence untouched
    cur_req = "R6"; issue(4, 5, 64'd7, 0, 12); issue(3, 5, 64'd1, 0, 13);
    issue(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 0, 14); issue(4, 6, 64'd2, 0, 15);
    issue(0, 6, 0, 0, 1); idle(1);
    // R10 / R7: fill the queue, hold off a parking request, admit a read
    cur_req = "R7";
    for (int i = 0; i < 4; i++) issue(2, 8 + i, 0, 0, 2 + i);
    idle(1);
    step(1, 2, 12, 0, 0, 9, acc);
    check("R10", acc == 0, "full queue hold-off", 64'(acc), 64'd0);
    step(1, 0, 12, 0, 0, 9, acc);
    check("R10", acc == 1, "read passes full queue", 64'(acc), 64'd1);
    issue(1, 9, 64'h99, 0, 6); idle(8);
    // R8: flip an unrelated word until the rest time out
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin issue(1, 13, 64'(i), 0, 7); issue(2, 13, 0, 0, 8); idle(4); end
    check("R8", timeouts_seen > 0, "timeouts observed", 64'(timeouts_seen), 64'd1);
    // R9: trap flags block access, retry sees trap too
    cur_req = "R9"; issue(5, 4, 0, 2'b01, 1); issue(0, 4, 0, 0, 2);
    issue(1, 4, 64'h5, 0, 3); issue(5, 4, 0, 2'b00, 4); issue(0, 4, 0, 0, 5);
    issue(2, 14, 0, 0, 6); issue(5, 14, 0, 2'b10, 7);
    issue(1, 15, 64'h1, 0, 8); idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule